// File: doc/BRIEF.md
# Burst Copy Engine with Length Check

This block is a single-channel engine that copies 32-bit words from one memory region to another. Software supplies a source byte address, a destination byte address, a length in bytes and a burst code, then pulses a start strobe. The engine moves the data in bursts. In each burst it reads a group of words into a local buffer and then writes the same group out. It repeats this until the byte count is used up, and then it raises a done flag.

The length counts bytes, but every unit moved is a whole word. A burst code of k selects bursts of 2^k words, for k from 0 to 4. A transfer is only accepted when its length is non-zero and a whole multiple of the burst size in bytes, which is 4·2^k. Any other request is refused at the start. The engine sets an error flag and stays idle, so it never runs a partial or runaway transfer.

The memory side is a plain synchronous port. Read data returns one cycle after a read request, and a write completes on the clock edge where it is requested. There is no arbitration with other masters.

Top module: `burst_dma`

## Requirements
- R1: After reset, busy, done and err are 0, and no memory read or write is requested.
- R2: A start with a length of 0 sets err, clears done, and leaves the engine idle (busy stays 0), with no memory access.
- R3: A start whose length is not a multiple of 4·2^k bytes, where k is the burst code, sets err and leaves the engine idle.
- R4: A start with a burst code above 4 sets err and leaves the engine idle, whatever the length.
- R5: A legal start while idle makes busy 1 on the next cycle and clears both err and done.
- R6: When a transfer ends, each of the length/4 destination words holds the value of the matching source word.
- R7: The n-th read (counting from 0) uses address src+4n, and the n-th write uses address dst+4n.
- R8: Bursts are processed in order. Before the write of word w, exactly (floor(w/B)+1)·B reads have been issued, where B = 2^k is the burst size in words.
- R9: In the cycle after the last write, busy is 0 and done is 1. Done then stays 1 until the next start.
- R10: A start pulse while busy is ignored. The running transfer finishes with its original addresses and length.
- R11: A transfer issues exactly length/4 reads and length/4 writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle request to begin a transfer |
| src_addr | input | AW | Source byte address, word aligned |
| dst_addr | input | AW | Destination byte address, word aligned |
| len_bytes | input | LW | Transfer length in bytes |
| burst_mode | input | 3 | Burst code k, burst = 2^k words |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | Last transfer completed |
| err | output | 1 | Last start request was refused |
| mem_rd | output | 1 | Memory read request |
| mem_raddr | output | AW | Read byte address |
| mem_rdata | input | 32 | Read data, valid the cycle after mem_rd |
| mem_wr | output | 1 | Memory write request |
| mem_waddr | output | AW | Write byte address |
| mem_wdata | output | 32 | Write data |

## Verification
A wrong burst index or a wrong remaining count shows up at the ports within one burst. The address sequence jumps by something other than 4, or the ratio of reads to writes breaks the per-burst order, so the bench's address and order checks flag it on the very access where it goes wrong. A wrong buffer slot leaves the address trace intact but puts the wrong word in the destination, which the memory comparison catches at the end of the transfer. A faulty length check shows up one cycle after start, as busy and err with the wrong values.

// File: rtl/burst_dma.sv
module burst_dma #(
  parameter int AW       = 16,
  parameter int LW       = 16,
  parameter int MODE_MAX = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] src_addr,
  input  logic [AW-1:0] dst_addr,
  input  logic [LW-1:0] len_bytes,
  input  logic [2:0]    burst_mode,
  output logic          busy,
  output logic          done,
  output logic          err,
  output logic          mem_rd,
  output logic [AW-1:0] mem_raddr,
  input  logic [31:0]   mem_rdata,
  output logic          mem_wr,
  output logic [AW-1:0] mem_waddr,
  output logic [31:0]   mem_wdata
);
  localparam int BUFD = 1 << MODE_MAX;
  localparam int IW   = (MODE_MAX > 0) ? MODE_MAX : 1;

  typedef enum logic [1:0] {S_IDLE, S_RD, S_RWAIT, S_WR} st_t;
  st_t st;

  logic [AW-1:0] src_q, dst_q;
  logic [LW-1:0] rem_q;
  logic [2:0]    mode_q;
  logic [IW-1:0] idx_q, ridx_q;
  logic          rd_q;
  logic [31:0]   buf_q [BUFD];

  logic [LW-1:0] req_mask;
  logic          legal;
  logic [IW-1:0] last_idx;
  logic [LW-1:0] burst_bytes;

  assign req_mask    = (LW'(4) << burst_mode) - LW'(1);
  assign legal       = (burst_mode <= 3'(MODE_MAX)) && (len_bytes != '0) &&
                       ((len_bytes & req_mask) == '0);
  assign last_idx    = IW'((1 << mode_q) - 1);
  assign burst_bytes = LW'(4) << mode_q;

  assign busy      = (st != S_IDLE);
  assign mem_rd    = (st == S_RD);
  assign mem_raddr = src_q;
  assign mem_wr    = (st == S_WR);
  assign mem_waddr = dst_q;
  assign mem_wdata = buf_q[idx_q];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      done   <= 1'b0;
      err    <= 1'b0;
      src_q  <= '0;
      dst_q  <= '0;
      rem_q  <= '0;
      mode_q <= '0;
      idx_q  <= '0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          done <= 1'b0;
          if (legal) begin
            err    <= 1'b0;
            src_q  <= src_addr;
            dst_q  <= dst_addr;
            rem_q  <= len_bytes;
            mode_q <= burst_mode;
            idx_q  <= '0;
            st     <= S_RD;
          end else begin
            err <= 1'b1;
          end
        end
        S_RD: begin
          src_q <= src_q + AW'(4);
          if (idx_q == last_idx) begin
            idx_q <= '0;
            st    <= S_RWAIT;
          end else begin
            idx_q <= idx_q + IW'(1);
          end
        end
        S_RWAIT: st <= S_WR;
        S_WR: begin
          dst_q <= dst_q + AW'(4);
          if (idx_q == last_idx) begin
            idx_q <= '0;
            rem_q <= rem_q - burst_bytes;
            if (rem_q == burst_bytes) begin
              done <= 1'b1;
              st   <= S_IDLE;
            end else begin
              st <= S_RD;
            end
          end else begin
            idx_q <= idx_q + IW'(1);
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_q   <= 1'b0;
      ridx_q <= '0;
    end else begin
      rd_q   <= mem_rd;
      ridx_q <= idx_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rd_q) buf_q[ridx_q] <= mem_rdata;
  end

  // R9: finishing leaves the engine idle
  a_r9_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  // R9: done holds until a new start
  a_r9_done_holds: assert property (@(posedge clk) disable iff (!rst_n)
    done && !start |=> done);
  // R5: legal request accepted
  a_r5_accept: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy && legal |=> busy && !err && !done);
  // R3/R4: illegal request refused
  a_r4_reject: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy && !legal |=> err && !busy);
  // R7: read and write addresses advance by one word
  a_r7_src_step: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd && $past(mem_rd) |-> mem_raddr == $past(mem_raddr) + AW'(4));
  a_r7_dst_step: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr && $past(mem_wr) |-> mem_waddr == $past(mem_waddr) + AW'(4));
  // R11: a running transfer always has bytes left
  a_r11_rem_live: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> rem_q != '0);
endmodule

// File: tb/burst_dma_tb.sv
module burst_dma_tb;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 16;
  localparam int LW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [AW-1:0] src_addr = '0, dst_addr = '0;
  logic [LW-1:0] len_bytes = '0;
  logic [2:0]    burst_mode = '0;
  logic          busy, done, err, mem_rd, mem_wr;
  logic [AW-1:0] mem_raddr, mem_waddr;
  logic [31:0]   mem_rdata, mem_wdata;

  int tests = 0, fails = 0;
  logic [31:0] mem [4096];

  int rd_cnt, wr_cnt, bwords;
  logic [AW-1:0] exp_src, exp_dst;

  burst_dma #(.AW(AW), .LW(LW), .MODE_MAX(4)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .src_addr(src_addr),
    .dst_addr(dst_addr), .len_bytes(len_bytes), .burst_mode(burst_mode),
    .busy(busy), .done(done), .err(err), .mem_rd(mem_rd),
    .mem_raddr(mem_raddr), .mem_rdata(mem_rdata), .mem_wr(mem_wr),
    .mem_waddr(mem_waddr), .mem_wdata(mem_wdata));

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    if (mem_rd) mem_rdata <= mem[mem_raddr[13:2]];
    if (mem_wr) mem[mem_waddr[13:2]] <= mem_wdata;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit is_legal(input int len, input int mode);
    if (mode > 4 || len == 0) return 0;
    return (len % (4 << mode)) == 0;
  endfunction

  always @(negedge clk) begin
    if (rst_n && mem_rd) begin
      check(mem_raddr == exp_src + AW'(4*rd_cnt), "R7 read addr", mem_raddr, exp_src + AW'(4*rd_cnt));
      rd_cnt++;
    end
    if (rst_n && mem_wr) begin
      check(mem_waddr == exp_dst + AW'(4*wr_cnt), "R7 write addr", mem_waddr, exp_dst + AW'(4*wr_cnt));
      check(rd_cnt == (wr_cnt / bwords + 1) * bwords, "R8 burst order", rd_cnt, (wr_cnt / bwords + 1) * bwords);
      wr_cnt++;
    end
  end

  task automatic pulse(input int s, input int d, input int len, input int mode);
    @(negedge clk);
    src_addr = AW'(s); dst_addr = AW'(d); len_bytes = LW'(len); burst_mode = 3'(mode);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic run_xfer(input int s, input int d, input int len, input int mode, input bit poke);
    logic [31:0] ref_w [];
    int n, lim;
    n = len / 4;
    ref_w = new[n];
    for (int i = 0; i < n; i++) ref_w[i] = mem[(s/4 + i) % 4096];
    rd_cnt = 0; wr_cnt = 0; bwords = 1 << mode;
    exp_src = AW'(s); exp_dst = AW'(d);
    pulse(s, d, len, mode);
    check(busy && !err && !done, "R5 accepted", {busy, err, done}, 3'b100);
    if (poke) begin
      pulse(s + 64, d + 128, 4, 0);
      check(busy, "R10 still busy", busy, 1);
    end
    lim = 0;
    while (!done && lim < 4000) begin @(negedge clk); lim++; end
    check(done && !busy, "R9 done raised", {done, busy}, 2'b10);
    check(rd_cnt == n, "R11 read count", rd_cnt, n);
    check(wr_cnt == n, "R11 write count", wr_cnt, n);
    for (int i = 0; i < n; i++)
      check(mem[(d/4 + i) % 4096] == ref_w[i], "R6 data", mem[(d/4 + i) % 4096], ref_w[i]);
    repeat (3) @(negedge clk);
    check(done && !busy && !mem_rd && !mem_wr, "R9 done holds", {done, busy}, 2'b10);
  endtask

  task automatic expect_reject(input int len, input int mode, input string req);
    int r0;
    r0 = rd_cnt;
    pulse(0, 32'h2000, len, mode);
    check(err && !busy && !done, req, {err, busy, done}, 3'b100);
    @(negedge clk);
    check(!busy && rd_cnt == r0, {req, " idle"}, rd_cnt, r0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++; tests++;
    $display("FAIL watchdog actual=hang expected=finish");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int s, d, mode, len;
    void'($urandom(32'd20240611));
    for (int i = 0; i < 4096; i++) mem[i] = $urandom;
    rd_cnt = 0; wr_cnt = 0; bwords = 1;
    repeat (3) @(negedge clk);
    check(!busy && !done && !err && !mem_rd && !mem_wr, "R1 reset", {busy, done, err}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    expect_reject(0, 0, "R2 zero length");
    run_xfer(32'h0100, 32'h2000, 4, 0, 0);
    expect_reject(0, 3, "R2 zero length mode3");
    expect_reject(6, 0, "R3 not word multiple");
    expect_reject(24, 3, "R3 not burst multiple");
    expect_reject(32, 4, "R3 below minimum");
    expect_reject(64, 5, "R4 mode above 4");
    expect_reject(128, 7, "R4 mode 7");
    run_xfer(32'h0200, 32'h2400, 64, 4, 0);
    run_xfer(32'h0300, 32'h2800, 256, 4, 0);
    run_xfer(32'h0400, 32'h2C00, 96, 3, 1);

    for (int t = 0; t < 30; t++) begin
      mode = $urandom % 8;
      len = ($urandom % 5 == 0) ? ($urandom % 200) : (4 << (mode % 5)) * (1 + $urandom % 4);
      s = ($urandom % 512) * 4;
      d = 32'h2000 + ($urandom % 512) * 4;
      if (is_legal(len, mode)) run_xfer(s, d, len, mode, t % 7 == 0);
      else if (mode > 4) expect_reject(len, mode, "R4 random");
      else if (len == 0) expect_reject(len, mode, "R2 random");
      else expect_reject(len, mode, "R3 random");
    end

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule